// File: doc/BRIEF.md
# Linked-List DMA Descriptor Walker

This block drives one DMA channel from a chain of transfer elements held in memory. Software writes the address of the first element and rings a doorbell. The walker then reads each element as a series of 32-bit words over a simple read port. For each data element it hands source, destination and byte count to an external data mover through a request/done handshake. When the mover reports done, the walker moves on to the element that follows it in memory.

An element counts as valid only while its change bit equals the walker's cycle state. When the walker meets a stale element it parks with a stopped flag. Software can then refill the memory and ring the doorbell again so that the walker re-reads the same element. A link element redirects the walk to another address and can invert the cycle state. Software can therefore recycle one fixed memory region for many segments. Completion flags in a data element raise a local done status or a remote done pulse. A failed memory read aborts the walk and records where it failed. A small word-addressed register set holds these controls and reports status.

Top module: `lldma_walker`

## Requirements
- R1: After reset the walker is idle. No memory or mover request is raised, `irq_o` is low, and the interrupt status (index 3), the done count (index 6) and the state register (index 5) all read 0.
- R2: Elements are read as 32-bit words at ascending addresses, starting at the element address. A data element has six words: control, length in bytes, source low, source high, destination low, destination high. The next element starts 24 bytes after the current one. A memory request and a mover request are never raised together.
- R3: Each valid data element produces exactly one mover request carrying its source, destination and length. The request holds these values stable until `mv_done`.
- R4: Bit 0 of the control word is the change bit. If it differs from the cycle state, the walker issues no transfer, goes idle and sets the stopped flag (state bit 1).
- R5: When a data element with control bit 3 completes, done status bit 0 is set. When a data element with control bit 4 completes, `remote_done_o` pulses for one cycle, in the cycle after `mv_done`. Elements without bit 4 produce no pulse.
- R6: Control bit 2 marks a link element. Its four words are control, reserved, pointer low and pointer high. The walk continues at the pointer. Control bit 1 of a link element inverts the cycle state.
- R7: A write to the doorbell (index 2) with bit 0 set restarts the walk at the base address (indices 0 and 1, low and high) with the cycle state taken from bit 1. With bit 0 clear, the walker re-reads the element where it stopped and keeps the current cycle state. A doorbell written while busy is ignored.
- R8: If a read returns an error, the walker sets abort status bit 1, stores the start address of the failing element (indices 7 and 8, low and high) and goes idle.
- R9: The done count (index 6) rises by one for every completed data element.
- R10: Writing 1 to an interrupt status bit clears it. A new event in the same cycle wins. The enable register (index 4: bit 0 done, bit 1 abort) gates the bits, and `irq_o` is the OR of the enabled status bits.
- R11: The state register (index 5) reads bit 0 busy, bit 1 stopped and bit 2 the current cycle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Element word read request |
| mem_addr | output | 64 | Byte address of the requested word |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response word |
| mem_rerr | input | 1 | Read response error |
| mv_req | output | 1 | Transfer request to the data mover |
| mv_src | output | 64 | Transfer source address |
| mv_dst | output | 64 | Transfer destination address |
| mv_len | output | 32 | Transfer length in bytes |
| mv_done | input | 1 | Data mover completion |
| irq_o | output | 1 | Interrupt, OR of enabled status bits |
| remote_done_o | output | 1 | One-cycle remote completion pulse |

## Verification
The bench builds the walker with its default 16-bit done counter. At that width the cumulative count across all scenarios stays well inside range, so every completion shows up as an exact value.

The memory responder stalls at random, and the data mover answers after random delays. This exposes words that arrive one per cycle or with gaps, and mover requests that must stay stable over many cycles. The directed scenarios cover:
- a stale element
- a resume through the doorbell
- a toggling link into a second segment
- an error on a middle word
- a doorbell rung while a transfer is held open

// File: rtl/lldma_pkg.sv
package lldma_pkg;
    localparam int unsigned WORD_BYTES = 4;
    localparam int unsigned DATA_WORDS = 6;
    localparam int unsigned DATA_BYTES = DATA_WORDS * WORD_BYTES;

    // control word bit positions
    localparam int unsigned CB_BIT   = 0;
    localparam int unsigned TOG_BIT  = 1;
    localparam int unsigned LINK_BIT = 2;
    localparam int unsigned LIE_BIT  = 3;
    localparam int unsigned RIE_BIT  = 4;
    localparam int unsigned CTL_W    = 5;

    // register word indices
    localparam logic [3:0] RA_BASE_LO = 4'd0;
    localparam logic [3:0] RA_BASE_HI = 4'd1;
    localparam logic [3:0] RA_BELL    = 4'd2;
    localparam logic [3:0] RA_ISR     = 4'd3;
    localparam logic [3:0] RA_IEN     = 4'd4;
    localparam logic [3:0] RA_STATE   = 4'd5;
    localparam logic [3:0] RA_COUNT   = 4'd6;
    localparam logic [3:0] RA_FAIL_LO = 4'd7;
    localparam logic [3:0] RA_FAIL_HI = 4'd8;

    typedef enum logic [1:0] {
        WK_IDLE  = 2'd0,
        WK_FETCH = 2'd1,
        WK_MOVE  = 2'd2
    } wk_state_e;
endpackage

// File: rtl/lldma_walk.sv
module lldma_walk
    import lldma_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kick,
    input  logic             kick_restart,
    input  logic             kick_cyc,
    input  logic [63:0]      base_addr,
    output logic             mem_req,
    output logic [63:0]      mem_addr,
    input  logic             mem_rvalid,
    input  logic [31:0]      mem_rdata,
    input  logic             mem_rerr,
    output logic             mv_req,
    output logic [63:0]      mv_src,
    output logic [63:0]      mv_dst,
    output logic [31:0]      mv_len,
    input  logic             mv_done,
    output logic             ev_done,
    output logic             ev_abort,
    output logic [63:0]      fail_addr,
    output logic             busy,
    output logic             stopped,
    output logic             cyc,
    output logic [CNT_W-1:0] cnt,
    output logic             remote_done
);
    typedef struct packed {
        wk_state_e        st;
        logic [63:0]      ea;
        logic [2:0]       widx;
        logic [CTL_W-1:0] ctl;
        logic [31:0]      len;
        logic [63:0]      src;
        logic [63:0]      dst;
        logic             cyc;
        logic             stopped;
        logic [CNT_W-1:0] cnt;
        logic             rmt;
        logic [63:0]      fail;
    } walk_t;

    walk_t wk_d, wk_q;

    always_comb begin
        wk_d     = wk_q;
        wk_d.rmt = 1'b0;
        ev_done  = 1'b0;
        ev_abort = 1'b0;
        case (wk_q.st)
            WK_IDLE: begin
                if (kick) begin
                    wk_d.st      = WK_FETCH;
                    wk_d.widx    = 3'd0;
                    wk_d.stopped = 1'b0;
                    if (kick_restart) begin
                        wk_d.ea  = base_addr;
                        wk_d.cyc = kick_cyc;
                    end
                end
            end
            WK_FETCH: begin
                if (mem_rvalid) begin
                    if (mem_rerr) begin
                        ev_abort  = 1'b1;
                        wk_d.fail = wk_q.ea;
                        wk_d.st   = WK_IDLE;
                    end else begin
                        wk_d.widx = wk_q.widx + 3'd1;
                        case (wk_q.widx)
                            3'd0: begin
                                if (mem_rdata[CB_BIT] != wk_q.cyc) begin
                                    wk_d.st      = WK_IDLE;
                                    wk_d.stopped = 1'b1;
                                    wk_d.widx    = 3'd0;
                                end else begin
                                    wk_d.ctl = mem_rdata[CTL_W-1:0];
                                end
                            end
                            3'd1: wk_d.len = mem_rdata;
                            3'd2: wk_d.src[31:0] = mem_rdata;
                            3'd3: begin
                                if (wk_q.ctl[LINK_BIT]) begin
                                    wk_d.ea   = {mem_rdata, wk_q.src[31:0]};
                                    wk_d.cyc  = wk_q.cyc ^ wk_q.ctl[TOG_BIT];
                                    wk_d.widx = 3'd0;
                                end else begin
                                    wk_d.src[63:32] = mem_rdata;
                                end
                            end
                            3'd4: wk_d.dst[31:0] = mem_rdata;
                            default: begin
                                wk_d.dst[63:32] = mem_rdata;
                                wk_d.st         = WK_MOVE;
                                wk_d.widx       = 3'd0;
                            end
                        endcase
                    end
                end
            end
            default: begin
                if (mv_done) begin
                    wk_d.cnt  = wk_q.cnt + 1'b1;
                    ev_done   = wk_q.ctl[LIE_BIT];
                    wk_d.rmt  = wk_q.ctl[RIE_BIT];
                    wk_d.ea   = wk_q.ea + 64'(DATA_BYTES);
                    wk_d.widx = 3'd0;
                    wk_d.st   = WK_FETCH;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wk_q <= '0;
        else        wk_q <= wk_d;
    end

    assign mem_req     = (wk_q.st == WK_FETCH);
    assign mem_addr    = wk_q.ea + {59'd0, wk_q.widx, 2'b00};
    assign mv_req      = (wk_q.st == WK_MOVE);
    assign mv_src      = wk_q.src;
    assign mv_dst      = wk_q.dst;
    assign mv_len      = wk_q.len;
    assign fail_addr   = wk_q.fail;
    assign busy        = (wk_q.st != WK_IDLE);
    assign stopped     = wk_q.stopped;
    assign cyc         = wk_q.cyc;
    assign cnt         = wk_q.cnt;
    assign remote_done = wk_q.rmt;
endmodule

// File: rtl/lldma_regs.sv
module lldma_regs
    import lldma_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [3:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             ev_done,
    input  logic             ev_abort,
    input  logic [63:0]      fail_addr,
    input  logic             busy,
    input  logic             stopped,
    input  logic             cyc,
    input  logic [CNT_W-1:0] cnt,
    output logic [63:0]      base_addr,
    output logic             kick,
    output logic             kick_restart,
    output logic             kick_cyc,
    output logic             irq_o
);
    typedef struct packed {
        logic [63:0] base;
        logic [1:0]  isr;
        logic [1:0]  ien;
    } regs_t;

    regs_t rg_d, rg_q;

    always_comb begin
        rg_d = rg_q;
        if (reg_we) begin
            case (reg_addr)
                RA_BASE_LO: rg_d.base[31:0]  = reg_wdata;
                RA_BASE_HI: rg_d.base[63:32] = reg_wdata;
                RA_ISR:     rg_d.isr         = rg_q.isr & ~reg_wdata[1:0];
                RA_IEN:     rg_d.ien         = reg_wdata[1:0];
                default: ;
            endcase
        end
        rg_d.isr = rg_d.isr | {ev_abort, ev_done};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        case (reg_addr)
            RA_BASE_LO: reg_rdata = rg_q.base[31:0];
            RA_BASE_HI: reg_rdata = rg_q.base[63:32];
            RA_ISR:     reg_rdata = {30'd0, rg_q.isr};
            RA_IEN:     reg_rdata = {30'd0, rg_q.ien};
            RA_STATE:   reg_rdata = {29'd0, cyc, stopped, busy};
            RA_COUNT:   reg_rdata = 32'(cnt);
            RA_FAIL_LO: reg_rdata = fail_addr[31:0];
            RA_FAIL_HI: reg_rdata = fail_addr[63:32];
            default:    reg_rdata = 32'd0;
        endcase
    end

    assign kick         = reg_we && (reg_addr == RA_BELL) && !busy;
    assign kick_restart = reg_wdata[0];
    assign kick_cyc     = reg_wdata[1];
    assign base_addr    = rg_q.base;
    assign irq_o        = |(rg_q.isr & rg_q.ien);
endmodule

// File: rtl/lldma_walker.sv
module lldma_walker
    import lldma_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic [63:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    input  logic        mem_rerr,
    output logic        mv_req,
    output logic [63:0] mv_src,
    output logic [63:0] mv_dst,
    output logic [31:0] mv_len,
    input  logic        mv_done,
    output logic        irq_o,
    output logic        remote_done_o
);
    logic             kick, kick_restart, kick_cyc;
    logic [63:0]      base_addr, fail_addr;
    logic             ev_done, ev_abort, busy, stopped, cyc;
    logic [CNT_W-1:0] done_cnt;

    lldma_walk #(.CNT_W(CNT_W)) u_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .kick         (kick),
        .kick_restart (kick_restart),
        .kick_cyc     (kick_cyc),
        .base_addr    (base_addr),
        .mem_req      (mem_req),
        .mem_addr     (mem_addr),
        .mem_rvalid   (mem_rvalid),
        .mem_rdata    (mem_rdata),
        .mem_rerr     (mem_rerr),
        .mv_req       (mv_req),
        .mv_src       (mv_src),
        .mv_dst       (mv_dst),
        .mv_len       (mv_len),
        .mv_done      (mv_done),
        .ev_done      (ev_done),
        .ev_abort     (ev_abort),
        .fail_addr    (fail_addr),
        .busy         (busy),
        .stopped      (stopped),
        .cyc          (cyc),
        .cnt          (done_cnt),
        .remote_done  (remote_done_o)
    );

    lldma_regs #(.CNT_W(CNT_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_we       (reg_we),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .ev_done      (ev_done),
        .ev_abort     (ev_abort),
        .fail_addr    (fail_addr),
        .busy         (busy),
        .stopped      (stopped),
        .cyc          (cyc),
        .cnt          (done_cnt),
        .base_addr    (base_addr),
        .kick         (kick),
        .kick_restart (kick_restart),
        .kick_cyc     (kick_cyc),
        .irq_o        (irq_o)
    );
endmodule

// File: rtl/lldma_walker_chk.sv
module lldma_walker_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_req,
    input logic             mem_rvalid,
    input logic             mem_rerr,
    input logic             mv_req,
    input logic [63:0]      mv_src,
    input logic [63:0]      mv_dst,
    input logic [31:0]      mv_len,
    input logic             mv_done,
    input logic             remote_done_o,
    input logic [CNT_W-1:0] cnt
);
    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && mv_req)); // R2

    AST_MOVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_req && !mv_done) |=> (mv_req && $stable(mv_src) && $stable(mv_dst) && $stable(mv_len))); // R3

    AST_REMOTE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        remote_done_o |-> $past(mv_req && mv_done)); // R5

    AST_ABORT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_rvalid && mem_rerr) |=> (!mem_req && !mv_req)); // R8

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_req && mv_done) |=> (cnt == $past(cnt) + 1'b1)); // R9
endmodule

bind lldma_walker lldma_walker_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_req       (mem_req),
    .mem_rvalid    (mem_rvalid),
    .mem_rerr      (mem_rerr),
    .mv_req        (mv_req),
    .mv_src        (mv_src),
    .mv_dst        (mv_dst),
    .mv_len        (mv_len),
    .mv_done       (mv_done),
    .remote_done_o (remote_done_o),
    .cnt           (done_cnt)
);

// File: tb/lldma_walker_test.sv
module lldma_walker_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = 32'd0;
    logic        mem_rerr = 1'b0;
    logic        mv_req;
    logic [63:0] mv_src, mv_dst;
    logic [31:0] mv_len;
    logic        mv_done = 1'b0;
    logic        irq_o, remote_done_o;

    lldma_walker uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .mem_rerr(mem_rerr), .mv_req(mv_req), .mv_src(mv_src), .mv_dst(mv_dst),
        .mv_len(mv_len), .mv_done(mv_done), .irq_o(irq_o),
        .remote_done_o(remote_done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] mem [0:255];
    logic [63:0] err_addr = '1;
    logic        mv_hold = 1'b0;
    int          rmt_seen = 0;
    logic [63:0] exp_src [0:63];
    logic [63:0] exp_dst [0:63];
    logic [31:0] exp_len [0:63];
    logic [63:0] log_src [0:63];
    logic [63:0] log_dst [0:63];
    logic [31:0] log_len [0:63];
    int exp_n = 0;
    int log_n = 0;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp, string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
        summary();
    end

    // memory responder with random stalls
    initial forever begin
        @(negedge clk);
        if (mem_req && ($urandom % 4 != 0)) begin
            mem_rvalid = 1'b1;
            mem_rdata  = (mem_addr < 64'd1024) ? mem[mem_addr[9:2]] : 32'd0;
            mem_rerr   = (mem_addr == err_addr);
        end else begin
            mem_rvalid = 1'b0;
            mem_rerr   = 1'b0;
        end
    end

    // data mover with random latency
    initial forever begin
        @(negedge clk);
        if (remote_done_o) rmt_seen++;
        if (mv_req && !mv_hold && ($urandom % 3 != 0)) begin
            mv_done = 1'b1;
            if (log_n < 64) begin
                log_src[log_n] = mv_src;
                log_dst[log_n] = mv_dst;
                log_len[log_n] = mv_len;
            end
            log_n++;
        end else begin
            mv_done = 1'b0;
        end
    end

    task automatic wreg(logic [3:0] a, logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rreg(logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic put_data(int a, bit cb, bit lie, bit rie, logic [31:0] len,
                            logic [63:0] src, logic [63:0] dst, bit expect_it);
        mem[a/4]     = {27'd0, rie, lie, 1'b0, 1'b0, cb};
        mem[a/4 + 1] = len;
        mem[a/4 + 2] = src[31:0];
        mem[a/4 + 3] = src[63:32];
        mem[a/4 + 4] = dst[31:0];
        mem[a/4 + 5] = dst[63:32];
        if (expect_it) begin
            exp_src[exp_n] = src; exp_dst[exp_n] = dst; exp_len[exp_n] = len;
            exp_n++;
        end
    endtask

    task automatic put_rand(int a, bit cb, bit lie, bit rie, bit expect_it);
        put_data(a, cb, lie, rie, ($urandom % 32'hFFFF_FFFF) + 32'd1,
                 {$urandom, $urandom}, {$urandom, $urandom}, expect_it);
    endtask

    task automatic put_link(int a, bit cb, bit tog, logic [63:0] ptr);
        mem[a/4]     = {29'd0, 1'b1, tog, cb};
        mem[a/4 + 1] = 32'd0;
        mem[a/4 + 2] = ptr[31:0];
        mem[a/4 + 3] = ptr[63:32];
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rreg(4'd5, v);
        while (v[0]) rreg(4'd5, v);
    endtask

    task automatic check_xfers(string req);
        chk(req, 64'(log_n), 64'(exp_n), "transfer count");
        for (int i = 0; i < exp_n && i < log_n && i < 64; i++) begin
            chk(req, log_src[i], exp_src[i], "source");
            chk(req, log_dst[i], exp_dst[i], "destination");
            chk(req, 64'(log_len[i]), 64'(exp_len[i]), "length");
        end
        exp_n = 0;
        log_n = 0;
    endtask

    initial begin
        logic [31:0] v;
        int exp_cnt;
        int exp_rmt;
        void'($urandom(32'd1234));
        for (int i = 0; i < 256; i++) mem[i] = 32'd0;
        repeat (3) @(negedge clk);
        chk("R1", {63'd0, mem_req}, 64'd0, "mem_req after reset");
        chk("R1", {63'd0, mv_req}, 64'd0, "mv_req after reset");
        chk("R1", {63'd0, irq_o}, 64'd0, "irq during reset");
        rst_n = 1'b1;
        rreg(4'd3, v); chk("R1", 64'(v), 64'd0, "status after reset");
        rreg(4'd6, v); chk("R1", 64'(v), 64'd0, "count after reset");
        rreg(4'd5, v); chk("R1", 64'(v), 64'd0, "state after reset");

        wreg(4'd4, 32'd3);

        // R2 R3 R4 R5: three elements, last flagged, then a stale element
        put_rand(32'h100, 1'b1, 1'b0, 1'b0, 1'b1);
        put_rand(32'h118, 1'b1, 1'b0, 1'b0, 1'b1);
        put_rand(32'h130, 1'b1, 1'b1, 1'b1, 1'b1);
        put_rand(32'h148, 1'b0, 1'b0, 1'b0, 1'b0);
        wreg(4'd0, 32'h100);
        wreg(4'd1, 32'h0);
        wreg(4'd2, 32'd3);
        wait_idle();
        check_xfers("R3");
        rreg(4'd6, v); chk("R9", 64'(v), 64'd3, "count after first segment");
        rreg(4'd3, v); chk("R5", 64'(v), 64'd1, "done status");
        chk("R10", {63'd0, irq_o}, 64'd1, "irq with done enabled");
        rreg(4'd5, v); chk("R4", 64'(v), 64'd6, "state stopped cycle 1");
        chk("R5", 64'(rmt_seen), 64'd1, "remote pulses");

        // R10: write-one-to-clear
        wreg(4'd3, 32'd1);
        rreg(4'd3, v); chk("R10", 64'(v), 64'd0, "status after clear");
        chk("R10", {63'd0, irq_o}, 64'd0, "irq after clear");

        // R7 resume, R6 toggling link into a second segment
        put_rand(32'h148, 1'b1, 1'b0, 1'b0, 1'b1);
        put_link(32'h160, 1'b1, 1'b1, 64'h300);
        put_rand(32'h300, 1'b0, 1'b1, 1'b0, 1'b1);
        put_rand(32'h318, 1'b0, 1'b0, 1'b0, 1'b1);
        put_rand(32'h330, 1'b1, 1'b0, 1'b0, 1'b0);
        wreg(4'd2, 32'd0);
        wait_idle();
        check_xfers("R6");
        rreg(4'd6, v); chk("R9", 64'(v), 64'd6, "count after link");
        rreg(4'd5, v); chk("R6", 64'(v), 64'd2, "state stopped cycle 0");
        rreg(4'd3, v); chk("R5", 64'(v), 64'd1, "done from second segment");
        chk("R5", 64'(rmt_seen), 64'd1, "no remote pulse without flag");

        // random rounds from base 0 with random cycle state
        exp_cnt = 6;
        exp_rmt = 1;
        wreg(4'd0, 32'h0);
        for (int r = 0; r < 8; r++) begin
            bit c;
            bit any_lie;
            int n;
            c = 1'($urandom);
            n = 1 + int'($urandom % 5);
            any_lie = 1'b0;
            wreg(4'd3, 32'd3);
            for (int k = 0; k < n; k++) begin
                bit l, rr;
                l = 1'($urandom);
                rr = 1'($urandom);
                any_lie |= l;
                exp_rmt += int'(rr);
                put_rand(k * 24, c, l, rr, 1'b1);
            end
            put_rand(n * 24, ~c, 1'b1, 1'b1, 1'b0);
            exp_cnt += n;
            wreg(4'd2, {30'd0, c, 1'b1});
            wait_idle();
            check_xfers("R3");
            rreg(4'd6, v); chk("R9", 64'(v), 64'(exp_cnt), "count random round");
            rreg(4'd3, v); chk("R5", 64'(v), {63'd0, any_lie}, "done random round");
            rreg(4'd5, v); chk("R4", 64'(v), {61'd0, c, 2'b10}, "state random round");
            chk("R5", 64'(rmt_seen), 64'(exp_rmt), "remote pulses random");
        end

        // R8 abort on a middle word, abort masked first
        wreg(4'd3, 32'd3);
        wreg(4'd4, 32'd1);
        put_rand(32'h200, 1'b1, 1'b0, 1'b0, 1'b1);
        put_rand(32'h218, 1'b1, 1'b0, 1'b0, 1'b0);
        put_rand(32'h230, 1'b0, 1'b0, 1'b0, 1'b0);
        err_addr = 64'h220;
        wreg(4'd0, 32'h200);
        wreg(4'd2, 32'd3);
        wait_idle();
        check_xfers("R8");
        rreg(4'd3, v); chk("R8", 64'(v), 64'd2, "abort status");
        chk("R10", {63'd0, irq_o}, 64'd0, "abort masked");
        rreg(4'd7, v); chk("R8", 64'(v), 64'h218, "fail address low");
        rreg(4'd8, v); chk("R8", 64'(v), 64'h0, "fail address high");
        rreg(4'd5, v); chk("R11", 64'(v), 64'd4, "state after abort");
        wreg(4'd4, 32'd3);
        chk("R10", {63'd0, irq_o}, 64'd1, "abort enabled");
        err_addr = '1;
        exp_src[0] = {mem[32'h218/4 + 3], mem[32'h218/4 + 2]};
        exp_dst[0] = {mem[32'h218/4 + 5], mem[32'h218/4 + 4]};
        exp_len[0] = mem[32'h218/4 + 1];
        exp_n = 1;
        wreg(4'd2, 32'd0);
        wait_idle();
        check_xfers("R7");
        exp_cnt += 2;
        rreg(4'd6, v); chk("R9", 64'(v), 64'(exp_cnt), "count after resume");

        // R7 doorbell ignored while busy
        wreg(4'd3, 32'd3);
        put_rand(32'h000, 1'b1, 1'b0, 1'b0, 1'b1);
        put_rand(32'h018, 1'b1, 1'b0, 1'b0, 1'b1);
        put_rand(32'h030, 1'b0, 1'b0, 1'b0, 1'b0);
        wreg(4'd0, 32'h0);
        mv_hold = 1'b1;
        wreg(4'd2, 32'd3);
        repeat (20) @(negedge clk);
        rreg(4'd5, v); chk("R11", 64'(v), 64'd5, "busy while mover held");
        wreg(4'd0, 32'h100);
        wreg(4'd2, 32'd1);
        mv_hold = 1'b0;
        wait_idle();
        check_xfers("R7");
        exp_cnt += 2;
        rreg(4'd6, v); chk("R9", 64'(v), 64'(exp_cnt), "count after ignored bell");
        rreg(4'd5, v); chk("R7", 64'(v), 64'd6, "cycle kept after ignored bell");

        summary();
    end
endmodule